// File: doc/BRIEF.md
# Latched Serial-In Display Driver

This block is the logic core of a serial-in, parallel-out driver for multiplexed display segments or grids. A host shifts a bit stream into a chain of stages, one bit for each rising edge of a slow shift clock. The far end of the chain appears on a serial output, so several drivers can be chained on one data line. A level-sensitive strobe copies the chain into a bank of output latches. Each output then turns on either its source driver or its pull-down sink. A blanking input turns every source off and every sink on. The latched pattern is kept and comes back when blanking is released.

All logic runs on one system clock. The shift clock, serial data, strobe and blanking inputs are asynchronous to that clock and each passes through a synchronizer. A rising edge of the synchronized shift clock is turned into a one-cycle shift pulse. While the synchronized strobe is high, the latch bank is reloaded on every system clock. The number of stages is a parameter, so the same block serves 10-, 12-, 20- and 32-output versions.

Top module: `vfd_shift_driver`

## Requirements
- R1: While reset is active, and after it is released, every latch and stage reads 0: `src_en_o` is all zeros, `snk_en_o` is all ones and `sdout_o` is 0.
- R2: Each rising edge of `sclk_i` loads `sdin_i` into stage 0 and moves every stage k to stage k+1. The first bit shifted in therefore ends up at the highest output index.
- R3: A falling edge of `sclk_i`, a steady `sclk_i`, or a change of `sdin_i` without a rising edge of `sclk_i` leaves the stages unchanged.
- R4: `sdout_o` always shows the highest stage. After a full load, a further shift presents the next-lower bit of the loaded pattern on `sdout_o`, so drivers can be cascaded.
- R5: While `strobe_i` is high, the latches follow the stages, including every shift that happens while the strobe stays high.
- R6: While `strobe_i` is low, the latches hold their value whatever is shifted in.
- R7: While `blank_i` is high, `src_en_o` is all zeros and `snk_en_o` is all ones.
- R8: Blanking does not alter the latches. When `blank_i` falls, the outputs show the pattern that was latched before.
- R9: While `blank_i` is low, output k has `src_en_o[k]` = latch k and `snk_en_o[k]` = the inverse of latch k. A source and a sink are never both on.
- R10: The stage count `STAGES` is a parameter. A 10-stage instance holds the last 10 bits shifted in, with the most recent bit at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk_i | input | 1 | Shift clock (asynchronous); a rising edge shifts one bit |
| sdin_i | input | 1 | Serial data in (asynchronous) |
| strobe_i | input | 1 | Latch strobe, level sensitive (asynchronous) |
| blank_i | input | 1 | Blanking: high forces all sources off and all sinks on |
| sdout_o | output | 1 | Serial data out from the highest stage, for cascading |
| src_en_o | output | STAGES | Per-output source-driver enable |
| snk_en_o | output | STAGES | Per-output pull-down sink enable |

## Verification
The assertions observe the synchronized copies of the inputs. They take for granted that each asynchronous input is held at a level long enough to pass the synchronizer. In particular, serial data must already be stable when the synchronized shift clock rises, so that data and clock reach the shift logic in the same cycle. The stimulus holds every level of `sclk_i` for at least three system clocks. It changes `sdin_i` only while the shift clock is low or steady, and it gives strobe and blanking changes six clocks to settle before it samples the outputs.

// File: rtl/vfd_drv_pkg.sv
package vfd_drv_pkg;

  // Drive state of one output pin: source on, or pull-down sink on.
  typedef struct packed {
    logic src;
    logic snk;
  } drive_t;

  // Map a latched bit and the blanking level to a pin drive state.
  function automatic drive_t drive_of(input logic lat, input logic blank);
    drive_t d;
    d.src = lat & ~blank;
    d.snk = ~lat | blank;
    return d;
  endfunction

endpackage

// File: rtl/vfd_rst_sync.sv
module vfd_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] rs_q;

  // Asserts asynchronously; releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_o = rs_q[1];

endmodule

// File: rtl/vfd_in_sync.sv
module vfd_in_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/vfd_shift_chain.sv
module vfd_shift_chain #(
  parameter int STAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [STAGES-1:0] q_o,
  output logic              dout
);

  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o  = chain_q;
  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/vfd_latch_drive.sv
module vfd_latch_drive
  import vfd_drv_pkg::*;
#(
  parameter int STAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [STAGES-1:0] d_i,
  input  logic              blank,
  output logic [STAGES-1:0] latch_o,
  output logic [STAGES-1:0] src_o,
  output logic [STAGES-1:0] snk_o
);

  logic [STAGES-1:0] lat_q, lat_d;

  // Transparent while strobe is high: reload every clock.
  always_comb begin
    lat_d = lat_q;
    if (load_en) lat_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_pin
    drive_t drv;
    assign drv      = drive_of(lat_q[k], blank);
    assign src_o[k] = drv.src;
    assign snk_o[k] = drv.snk;
  end

  assign latch_o = lat_q;

endmodule

// File: rtl/vfd_shift_driver.sv
module vfd_shift_driver #(
  parameter int STAGES     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              strobe_i,
  input  logic              blank_i,
  output logic              sdout_o,
  output logic [STAGES-1:0] src_en_o,
  output logic [STAGES-1:0] snk_en_o
);

  localparam int IN_W = 4;

  logic            rst_sync_n;
  logic [IN_W-1:0] in_raw, in_s;
  logic            sclk_s, sdin_s, strobe_s, blank_s;
  logic            sclk_prev_q;
  logic            shift_pulse;
  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] latch_q;

  vfd_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // All controls share one synchronizer so they stay cycle-aligned.
  assign in_raw = {blank_i, strobe_i, sdin_i, sclk_i};

  vfd_in_sync #(.WIDTH(IN_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (in_raw),
    .q_o   (in_s)
  );

  assign {blank_s, strobe_s, sdin_s, sclk_s} = in_s;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_prev_q <= 1'b0;
    else             sclk_prev_q <= sclk_s;
  end

  assign shift_pulse = sclk_s & ~sclk_prev_q;

  vfd_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_pulse),
    .din      (sdin_s),
    .q_o      (shreg_q),
    .dout     (sdout_o)
  );

  vfd_latch_drive #(.STAGES(STAGES)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (strobe_s),
    .d_i     (shreg_q),
    .blank   (blank_s),
    .latch_o (latch_q),
    .src_o   (src_en_o),
    .snk_o   (snk_en_o)
  );

endmodule

// File: rtl/vfd_shift_driver_chk.sv
module vfd_shift_driver_chk #(
  parameter int STAGES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_pulse,
  input logic              sdin_s,
  input logic              strobe_s,
  input logic              blank_s,
  input logic [STAGES-1:0] shreg,
  input logic [STAGES-1:0] latch,
  input logic              sdout,
  input logic [STAGES-1:0] src,
  input logic [STAGES-1:0] snk
);

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (shreg[0] == $past(sdin_s)) &&
                    (shreg[STAGES-1:1] == $past(shreg[STAGES-2:0])));

  a_r3_no_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(shreg));

  a_r4_sdout_next: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> sdout == $past(shreg[STAGES-2]));

  a_r5_latch_follow: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_s |=> latch == $past(shreg));

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_s |=> $stable(latch));

  a_r7_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank_s |-> (src == '0) && (snk == '1));

  a_r9_follow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_s |-> (src == latch) && (snk == ~latch));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (src & snk) == '0);

endmodule

bind vfd_shift_driver vfd_shift_driver_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .shift_pulse (shift_pulse),
  .sdin_s      (sdin_s),
  .strobe_s    (strobe_s),
  .blank_s     (blank_s),
  .shreg       (shreg_q),
  .latch       (latch_q),
  .sdout       (sdout_o),
  .src         (src_en_o),
  .snk         (snk_en_o)
);

// File: tb/vfd_shift_driver_test.sv
module vfd_shift_driver_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, strobe = 1'b0, blank = 1'b0;
  logic        sdout, sdout10;
  logic [31:0] src, snk;
  logic [9:0]  src10, snk10;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] m;   // expected stage contents, built from R2

  always #2 clk = ~clk;   // 250 MHz

  vfd_shift_driver uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .strobe_i(strobe), .blank_i(blank),
    .sdout_o(sdout), .src_en_o(src), .snk_en_o(snk)
  );

  vfd_shift_driver #(.STAGES(10)) uut10 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .strobe_i(strobe), .blank_i(blank),
    .sdout_o(sdout10), .src_en_o(src10), .snk_en_o(snk10)
  );

  typedef struct packed {
    logic        blk;
    logic [31:0] pat;
    logic [31:0] exp_src;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    '{1'b0, 32'h0000_0001, 32'h0000_0001},
    '{1'b0, 32'h8000_0000, 32'h8000_0000},
    '{1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{1'b1, 32'h1234_5678, 32'h0000_0000},
    '{1'b0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdin = b;
    tick(3);
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
    tick(3);
    m = {m[30:0], b};
  endtask

  task automatic load(input logic [31:0] p);
    for (int i = 31; i >= 0; i--) shift_bit(p[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    tick(6);
    strobe = 1'b0;
    tick(6);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    m = '0;
    // R1: state while reset is held and just after release
    tick(3);
    chk("R1 src in reset", src, 32'h0);
    chk("R1 snk in reset", snk, 32'hFFFF_FFFF);
    chk("R1 sdout in reset", {31'h0, sdout}, 32'h0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 src after release", src, 32'h0);
    chk("R1 snk after release", snk, 32'hFFFF_FFFF);

    // Table walk: load with strobe low, latch, check outputs, then unblank
    for (int v = 0; v < NVEC; v++) begin
      blank = VEC[v].blk;
      load(VEC[v].pat);
      pulse_strobe();
      chk(VEC[v].blk ? "R7 src blanked" : "R9 src", src, VEC[v].exp_src);
      chk(VEC[v].blk ? "R7 snk blanked" : "R9 snk", snk,
          VEC[v].blk ? 32'hFFFF_FFFF : ~VEC[v].pat);
      chk("R4 sdout top stage", {31'h0, sdout}, {31'h0, VEC[v].pat[31]});
      chk("R10 ten-stage src", {22'h0, src10},
          {22'h0, VEC[v].blk ? 10'h0 : VEC[v].pat[9:0]});
      blank = 1'b0;
      tick(6);
      chk("R8 latch kept through blanking", src, VEC[v].pat);
    end

    // R4: cascade, one more shift exposes the next-lower bit
    m = 32'hC3C3_5A5A;
    load(32'hC3C3_5A5A);
    chk("R4 sdout after load", {31'h0, sdout}, 32'h1);
    shift_bit(1'b0);
    chk("R4 sdout after extra shift", {31'h0, sdout}, 32'h1);
    shift_bit(1'b0);
    chk("R4 sdout second extra shift", {31'h0, sdout}, 32'h0);

    // R5: strobe held high, latches track each shift (R2 ordering)
    strobe = 1'b1;
    tick(6);
    chk("R5 transparent on strobe", src, m);
    for (int i = 0; i < 5; i++) begin
      shift_bit(i[0]);
      tick(3);
      chk("R5 R2 latch tracks shift", src, m);
    end

    // R3: data changes and a held-high clock do not shift
    sdin = 1'b1;
    tick(3);
    sclk = 1'b1;
    tick(6);
    m = {m[30:0], 1'b1};
    for (int i = 0; i < 4; i++) begin
      sdin = ~sdin;
      tick(4);
    end
    sclk = 1'b0;
    tick(6);
    for (int i = 0; i < 4; i++) begin
      sdin = ~sdin;
      tick(4);
    end
    chk("R3 single shift per rising edge", src, m);

    // R6: strobe low, new data shifted but outputs hold
    strobe = 1'b0;
    tick(6);
    begin
      logic [31:0] held;
      held = m;
      for (int i = 0; i < 8; i++) shift_bit(1'b1);
      tick(3);
      chk("R6 latch holds with strobe low", src, held);
      chk("R6 sinks hold with strobe low", snk, ~held);
    end
    strobe = 1'b1;
    tick(6);
    chk("R5 new data latched on strobe", src, m);
    strobe = 1'b0;
    tick(3);

    // R1: reset in mid-operation clears everything
    rst_n = 1'b0;
    tick(3);
    chk("R1 src after mid reset", src, 32'h0);
    chk("R1 snk after mid reset", snk, 32'hFFFF_FFFF);
    chk("R1 sdout after mid reset", {31'h0, sdout}, 32'h0);
    rst_n = 1'b1;
    tick(6);

    done = 1'b1;
    finish_run();
  end

endmodule